// File: doc/BRIEF.md
# Commit-Priority Register Read Port Arbiter

This block hands out the register-file read ports of a K-wide issue machine. The machine has exactly 2K read ports. Each issue slot asks for zero, one or two source operands in a cycle. A return instruction reaching commit asks for one extra read, which fetches the link register (index 26) so that a shadow return-address check can compare it. Issue requests are packed onto the ports in slot order. The commit read takes the first port that issue leaves free. Only when issue has claimed every port does the arbiter stall the youngest slot that holds ports. It then gives the freed port to the commit read. The scheduler holds a stalled slot and presents it again in the next cycle.

The link read is granted in the cycle it is requested. A small state machine tracks the read as the data comes back one cycle later. It has two states, `LNK_IDLE` and `LNK_FETCH`. A commit grant moves it from `LNK_IDLE` to `LNK_FETCH` ("launch"). A further grant keeps it in `LNK_FETCH` ("chain"). A cycle without a grant returns it to `LNK_IDLE` ("drain"). In `LNK_FETCH` the value on the remembered port goes to the checker. A saturating counter records how many cycles issue lost to a commit read.

Top module: `link_read_port_arbiter`

## Requirements
- R1: Granted slots receive consecutive ports in slot order, starting at port 0. Within a slot, operand A takes the lower port and operand B the next one. `port_idx` carries the operand's register index. A request count of 3 is served as 2. Ports with no owner have `port_en` low.
- R2: Without a commit read request no slot is stalled and no `port_link` bit is set, even when all 2K ports are claimed.
- R3: With a commit read request and at least one free port, the link read goes to the lowest free port. That port has `port_en` and `port_link` high and `port_idx` = 26, and no slot stalls. At most one `port_link` bit is ever set.
- R4: With a commit read request while issue claims all 2K ports, only slot K-1 is stalled. Slots 0..K-2 keep ports 0..2K-3, the link read uses port 2K-2, and port 2K-1 is idle.
- R5: At most one slot is stalled in any cycle, and a stall occurs only together with a commit read request.
- R6: `link_vld` is high exactly in the cycle after a link grant. `link_data` then equals `port_rdata` of the port granted in the previous cycle.
- R7: `stall_cycles` rises by one at each clock edge where a slot was stalled and holds at its all-ones value once reached.
- R8: After reset `link_vld` is low and `stall_cycles` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_nsrc | input | K x 2 | Operand count requested by each issue slot (0..2, 3 served as 2) |
| slot_src_a | input | K x IDX_W | Register index of operand A per slot |
| slot_src_b | input | K x IDX_W | Register index of operand B per slot |
| commit_rd_req | input | 1 | Committing return needs the link register |
| port_rdata | input | 2K x DATA_W | Read data per port, one cycle after the address |
| port_en | output | 2K | Port carries a read this cycle |
| port_idx | output | 2K x IDX_W | Register index driven on each port |
| port_link | output | 2K | Port carries the commit link read |
| slot_stall | output | K | Slot must hold and retry next cycle |
| link_vld | output | 1 | Link register value valid for the checker |
| link_data | output | DATA_W | Link register value |
| stall_cycles | output | CNT_W | Saturating count of stalled issue cycles |

## Verification
The hardest case is the port steal. Every slot must ask for two operands in the same cycle that the commit read arrives. The returned link data must then be traced to port 2K-2 and not to the last port. The stimulus builds that full cycle directly and also follows it with the same slots without a commit request, to show the retried slot gets its ports back. Driving the full case many times in a row with a narrow counter reaches the saturation point quickly.

// File: rtl/rpa_pkg.sv
package rpa_pkg;

    typedef enum logic [0:0] {
        LNK_IDLE  = 1'b0,
        LNK_FETCH = 1'b1
    } lnk_state_t;

    // A request count of three is served as two operands (R1)
    function automatic logic [1:0] clamp_nsrc(input logic [1:0] n);
        return (n == 2'd3) ? 2'd2 : n;
    endfunction

endpackage

// File: rtl/rpa_alloc.sv
module rpa_alloc
    import rpa_pkg::*;
#(
    parameter int K        = 4,
    parameter int IDX_W    = 5,
    parameter int LINK_REG = 26,
    localparam int NPORT   = 2 * K,
    localparam int CW      = $clog2(NPORT + 1),
    localparam int PW      = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int SW      = (K > 1) ? $clog2(K) : 1
) (
    input  logic [K-1:0][1:0]           slot_nsrc,
    input  logic [K-1:0][IDX_W-1:0]     slot_src_a,
    input  logic [K-1:0][IDX_W-1:0]     slot_src_b,
    input  logic                        commit_rd_req,
    output logic [NPORT-1:0]            port_en,
    output logic [NPORT-1:0][IDX_W-1:0] port_idx,
    output logic [NPORT-1:0]            port_link,
    output logic [K-1:0]                slot_stall,
    output logic                        link_grant,
    output logic [PW-1:0]               link_port
);

    logic [K-1:0][1:0]   eff;
    logic [K-1:0][1:0]   gcnt;
    logic [K-1:0][CW-1:0] base;
    logic [CW-1:0]       total;
    logic [CW-1:0]       used;
    logic [SW-1:0]       young;
    logic                young_vld;
    logic                steal;

    for (genvar s = 0; s < K; s++) begin : g_eff
        assign eff[s]  = clamp_nsrc(slot_nsrc[s]);
        assign gcnt[s] = slot_stall[s] ? 2'd0 : eff[s];
    end

    // Demand and youngest requesting slot
    always_comb begin
        total     = '0;
        young     = '0;
        young_vld = 1'b0;
        for (int s = 0; s < K; s++) begin
            total = total + CW'(eff[s]);
            if (eff[s] != 2'd0) begin
                young_vld = 1'b1;
                young     = SW'(s);
            end
        end
    end

    assign steal      = commit_rd_req && young_vld && (total == CW'(NPORT));
    assign slot_stall = steal ? (K'(1) << young) : '0;

    // Port base of each granted slot
    always_comb begin
        base[0] = '0;
        for (int s = 1; s < K; s++) begin
            base[s] = base[s-1] + CW'(gcnt[s-1]);
        end
        used = base[K-1] + CW'(gcnt[K-1]);
    end

    assign link_grant = commit_rd_req && (used < CW'(NPORT));
    assign link_port  = PW'(used);

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            port_en[p]   = 1'b0;
            port_idx[p]  = '0;
            port_link[p] = 1'b0;
            for (int s = 0; s < K; s++) begin
                if (gcnt[s] != 2'd0 && base[s] == CW'(p)) begin
                    port_en[p]  = 1'b1;
                    port_idx[p] = slot_src_a[s];
                end
                if (gcnt[s] == 2'd2 && base[s] + CW'(1) == CW'(p)) begin
                    port_en[p]  = 1'b1;
                    port_idx[p] = slot_src_b[s];
                end
            end
            if (link_grant && used == CW'(p)) begin
                port_en[p]   = 1'b1;
                port_link[p] = 1'b1;
                port_idx[p]  = IDX_W'(LINK_REG);
            end
        end
    end

endmodule

// File: rtl/rpa_link_fsm.sv
module rpa_link_fsm
    import rpa_pkg::*;
#(
    parameter int NPORT  = 8,
    parameter int DATA_W = 64,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         link_grant,
    input  logic [PW-1:0]                link_port,
    input  logic [NPORT-1:0][DATA_W-1:0] port_rdata,
    output logic                         link_vld,
    output logic [DATA_W-1:0]            link_data
);

    lnk_state_t    state_q, state_d;
    logic [PW-1:0] port_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_IDLE:  state_d = link_grant ? LNK_FETCH : LNK_IDLE;   // launch
            LNK_FETCH: state_d = link_grant ? LNK_FETCH : LNK_IDLE;   // chain / drain
            default:   state_d = LNK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LNK_IDLE;
            port_q  <= '0;
        end else begin
            state_q <= state_d;
            if (link_grant) port_q <= link_port;
        end
    end

    always_comb begin
        link_vld  = 1'b0;
        link_data = '0;
        unique case (state_q)
            LNK_IDLE:  ;
            LNK_FETCH: begin
                link_vld  = 1'b1;
                link_data = port_rdata[port_q];
            end
            default:   ;
        endcase
    end

    p_link_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_grant |=> link_vld);
    p_link_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !link_grant |=> !link_vld);

endmodule

// File: rtl/rpa_stall_ctr.sv
module rpa_stall_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall_any,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          count <= '0;
        else if (stall_any && count != CMAX) count <= count + CNT_W'(1);
    end

    p_ctr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_any && count != CMAX) |=> count == $past(count) + CNT_W'(1));
    p_ctr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_any || count == CMAX) |=> $stable(count));

endmodule

// File: rtl/link_read_port_arbiter.sv
module link_read_port_arbiter
    import rpa_pkg::*;
#(
    parameter int K        = 4,
    parameter int IDX_W    = 5,
    parameter int DATA_W   = 64,
    parameter int CNT_W    = 16,
    parameter int LINK_REG = 26,
    localparam int NPORT   = 2 * K,
    localparam int PW      = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [K-1:0][1:0]             slot_nsrc,
    input  logic [K-1:0][IDX_W-1:0]       slot_src_a,
    input  logic [K-1:0][IDX_W-1:0]       slot_src_b,
    input  logic                          commit_rd_req,
    input  logic [NPORT-1:0][DATA_W-1:0]  port_rdata,
    output logic [NPORT-1:0]              port_en,
    output logic [NPORT-1:0][IDX_W-1:0]   port_idx,
    output logic [NPORT-1:0]              port_link,
    output logic [K-1:0]                  slot_stall,
    output logic                          link_vld,
    output logic [DATA_W-1:0]             link_data,
    output logic [CNT_W-1:0]              stall_cycles
);

    logic          link_grant;
    logic [PW-1:0] link_port;

    rpa_alloc #(.K(K), .IDX_W(IDX_W), .LINK_REG(LINK_REG)) u_alloc (
        .slot_nsrc     (slot_nsrc),
        .slot_src_a    (slot_src_a),
        .slot_src_b    (slot_src_b),
        .commit_rd_req (commit_rd_req),
        .port_en       (port_en),
        .port_idx      (port_idx),
        .port_link     (port_link),
        .slot_stall    (slot_stall),
        .link_grant    (link_grant),
        .link_port     (link_port)
    );

    rpa_link_fsm #(.NPORT(NPORT), .DATA_W(DATA_W)) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_grant (link_grant),
        .link_port  (link_port),
        .port_rdata (port_rdata),
        .link_vld   (link_vld),
        .link_data  (link_data)
    );

    rpa_stall_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall_any (|slot_stall),
        .count     (stall_cycles)
    );

    p_one_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_stall));
    p_stall_needs_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_stall) |-> commit_rd_req);
    p_link_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_link));
    p_link_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_link & ~port_en) == '0);
    p_commit_served_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_rd_req |-> (|port_link));
    p_no_commit_no_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_rd_req |-> (port_link == '0 && slot_stall == '0));
    p_full_steals_young_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_rd_req && port_en == '1 && !(|port_link)) |-> 1'b0);

endmodule

// File: tb/link_read_port_arbiter_bench.sv
module link_read_port_arbiter_bench;

    localparam int K = 4, NP = 8, IW = 5, DW = 8, CW = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [K-1:0][1:0]      slot_nsrc;
    logic [K-1:0][IW-1:0]   slot_src_a, slot_src_b;
    logic                   commit_rd_req;
    logic [NP-1:0][DW-1:0]  port_rdata;
    logic [NP-1:0]          port_en, port_link;
    logic [NP-1:0][IW-1:0]  port_idx;
    logic [K-1:0]           slot_stall;
    logic                   link_vld;
    logic [DW-1:0]          link_data;
    logic [CW-1:0]          stall_cycles;

    int n_chk = 0, n_fail = 0, exp_cnt = 0;

    always #4 clk = ~clk;

    link_read_port_arbiter #(.K(K), .IDX_W(IW), .DATA_W(DW), .CNT_W(CW)) u_link_read_port_arbiter (
        .clk(clk), .rst_n(rst_n), .slot_nsrc(slot_nsrc), .slot_src_a(slot_src_a),
        .slot_src_b(slot_src_b), .commit_rd_req(commit_rd_req), .port_rdata(port_rdata),
        .port_en(port_en), .port_idx(port_idx), .port_link(port_link),
        .slot_stall(slot_stall), .link_vld(link_vld), .link_data(link_data),
        .stall_cycles(stall_cycles)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_all(input logic [1:0] n, input logic c);
        for (int s = 0; s < K; s++) slot_nsrc[s] = n;
        commit_rd_req = c;
    endtask

    task automatic stall_seen();
        exp_cnt = (exp_cnt < 7) ? exp_cnt + 1 : 7;
    endtask

    task automatic t_reset();
        chk(link_vld == 1'b0, "R8 link_vld", 64'(link_vld), 0);
        chk(stall_cycles == 0, "R8 stall_cycles", 64'(stall_cycles), 0);
    endtask

    task automatic t_pack();
        @(negedge clk);
        slot_nsrc[0] = 2'd2; slot_nsrc[1] = 2'd1; slot_nsrc[2] = 2'd0; slot_nsrc[3] = 2'd3;
        commit_rd_req = 1'b0;
        #1;
        chk(port_en == 8'h1F, "R1 port_en", 64'(port_en), 64'h1F);
        chk(port_idx[0] == 1 && port_idx[1] == 2, "R1 slot0 ports", 64'({port_idx[1], port_idx[0]}), 64'({5'd2, 5'd1}));
        chk(port_idx[2] == 5, "R1 slot1 port", 64'(port_idx[2]), 5);
        chk(port_idx[3] == 13 && port_idx[4] == 14, "R1 slot3 clamp", 64'({port_idx[4], port_idx[3]}), 64'({5'd14, 5'd13}));
        chk(slot_stall == 0 && port_link == 0, "R2 no commit", 64'({slot_stall, port_link}), 0);
        @(negedge clk);
        set_all(2'd0, 1'b0);
        chk(link_vld == 1'b0, "R6 no grant no valid", 64'(link_vld), 0);
    endtask

    task automatic t_free();
        @(negedge clk);
        set_all(2'd2, 1'b1); slot_nsrc[3] = 2'd1;
        #1;
        chk(port_link == 8'h80, "R3 link port", 64'(port_link), 64'h80);
        chk(port_idx[7] == 26, "R3 link index", 64'(port_idx[7]), 26);
        chk(slot_stall == 0 && port_en == 8'hFF, "R3 no stall", 64'({slot_stall, port_en}), 64'h0FF);
        @(negedge clk);
        set_all(2'd0, 1'b0);
        chk(link_vld == 1'b1, "R6 valid", 64'(link_vld), 1);
        chk(link_data == 8'h73, "R6 data port7", 64'(link_data), 64'h73);
    endtask

    task automatic t_full();
        @(negedge clk);
        set_all(2'd2, 1'b1);
        #1;
        chk(slot_stall == 4'b1000, "R4 stall youngest", 64'(slot_stall), 64'h8);
        chk(port_en == 8'h7F && port_link == 8'h40, "R4 ports", 64'({port_en, port_link}), 64'h7F40);
        chk(port_idx[6] == 26 && port_idx[5] == 10, "R4 indices", 64'({port_idx[6], port_idx[5]}), 64'({5'd26, 5'd10}));
        stall_seen();
        @(negedge clk);
        commit_rd_req = 1'b0;
        chk(link_vld && link_data == 8'h63, "R6 data port6", 64'(link_data), 64'h63);
        chk(stall_cycles == CW'(exp_cnt), "R7 count step", 64'(stall_cycles), 64'(exp_cnt));
        #1;
        chk(slot_stall == 0 && port_en == 8'hFF && port_link == 0, "R2 full no commit", 64'({slot_stall, port_en, port_link}), 64'h0FF00);
        @(negedge clk);
        set_all(2'd0, 1'b0);
        chk(stall_cycles == CW'(exp_cnt), "R7 hold", 64'(stall_cycles), 64'(exp_cnt));
    endtask

    task automatic t_sat();
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            set_all(2'd2, 1'b1);
            #1;
            chk($countones(slot_stall) == 1, "R5 single stall", 64'(slot_stall), 64'h8);
            stall_seen();
        end
        @(negedge clk);
        set_all(2'd0, 1'b0);
        chk(stall_cycles == 3'd7, "R7 saturate", 64'(stall_cycles), 7);
        #1;
        chk(slot_stall == 0, "R5 idle no stall", 64'(slot_stall), 0);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) port_rdata[p] = DW'(p * 16 + 3);
        for (int s = 0; s < K; s++) begin
            slot_src_a[s] = IW'(4 * s + 1);
            slot_src_b[s] = IW'(4 * s + 2);
        end
        set_all(2'd0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pack();
        t_free();
        t_full();
        t_sat();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule